// File: doc/BRIEF.md
# Fused Two-Layer Tile Command Sequencer

This control block emits the ordered command stream that drives two chained convolution layers, split into a programmable number of parallel sublayers, without ever sending the intermediate feature map off chip. Input tiles form the outermost loop, and each tile covers every input channel. For a given tile and sublayer, layer-1 filters are fetched one at a time. Each one produces a single on-chip layer-2 input channel. That channel is then consumed against the matching channel of every layer-2 filter of the sublayer, one filter at a time, and after that the channel is dropped. Layer-2 partial sums stay on chip until every layer-1 filter of the sublayer has been processed, and only then is the sublayer's output tile written back.

Software programs four counts: tiles, sublayers, layer-1 filters per sublayer and layer-2 filters per sublayer. It then pulses start. Each command carries a type code and four indices, and it moves to the datapath over a valid/ready handshake. A one-cycle done pulse closes each pass. Three counters tally the DRAM traffic the pass requested, so it can be compared against closed-form totals.

Top module: `fts_seq`

## Requirements
- R1: After reset, busy, cmd_valid, done and err are 0 and all three traffic counters read 0.
- R2: Command type codes are LOAD_IN=0, LOAD_W1=1, CALC1=2, LOAD_W2=3, CALC2=4, STORE=5. For each tile t the pass issues LOAD_IN(t). Then for each sublayer j in ascending order, and for each layer-1 filter f1 in ascending order, it issues LOAD_W1(t,j,f1) and CALC1(t,j,f1), followed by the pair LOAD_W2(t,j,f1,f2), CALC2(t,j,f1,f2) for each f2 in ascending order. STORE(t,j) follows the last f1. Indices a command does not use read 0.
- R3: cmd_clear is 1 on every CALC2 with f1=0 and 0 on every other command.
- R4: Each input tile is loaded exactly once per pass, and the next tile's LOAD_IN comes only after STORE of the last sublayer of the current tile.
- R5: While cmd_valid is 1 and cmd_ready is 0, the command holds all of its fields unchanged and is not skipped.
- R6: In the cycle after the final STORE handshake, done is 1 for exactly one cycle, busy and cmd_valid are 0, and no command appears until the next start.
- R7: At the end of a pass the counters read: input reads = T, weight reads = T*C*F1*(1+F2), output writes = T*C. All three are cleared when a pass is accepted.
- R8: A start pulse while busy is ignored, and the running pass completes with its original counts.
- R9: A start with any count equal to zero is rejected. In the next cycle err is 1, busy and cmd_valid stay 0, and err stays 1 until a valid start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass (accepted only when idle) |
| cfg_tiles | input | IDX_W | Number of input tiles |
| cfg_subs | input | IDX_W | Number of sublayers |
| cfg_f1 | input | IDX_W | Layer-1 filters per sublayer |
| cfg_f2 | input | IDX_W | Layer-2 filters per sublayer |
| busy | output | 1 | Pass in progress |
| err | output | 1 | Last start rejected for a zero count |
| done | output | 1 | One-cycle end-of-pass pulse |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Datapath accepts command |
| cmd_type | output | 3 | Command type code |
| cmd_tile | output | IDX_W | Tile index |
| cmd_sub | output | IDX_W | Sublayer index |
| cmd_f1 | output | IDX_W | Layer-1 filter index |
| cmd_f2 | output | IDX_W | Layer-2 filter index |
| cmd_clear | output | 1 | Start a fresh layer-2 partial sum |
| cnt_in_rd | output | CNT_W | Input tile reads this pass |
| cnt_w_rd | output | CNT_W | Weight reads this pass |
| cnt_out_wr | output | CNT_W | Output tile writes this pass |

## Verification
The bench targets degenerate sizes where several loop levels wrap on the same command, such as all counts equal to one, or a single layer-2 filter with several layer-1 filters. A design with a wrong wrap order there would skip or repeat STORE, or would clear the partial sums at the wrong filter. Random back-pressure checks that a stalled command keeps its fields, since a sequencer that advanced on valid alone would lose commands and drift from the expected stream. A start pulsed mid-pass, and a start with a zero count, expose designs that restart mid-pass or begin an empty loop. The traffic totals expose a counter that also counts stalled cycles.

// File: rtl/fts_pkg.sv
// Shared command encoding for the fused two-layer sequencer.
// Assumes a 3-bit command type field that the datapath decodes.
package fts_pkg;
    typedef enum logic [2:0] {
        CMD_LOAD_IN = 3'd0,
        CMD_LOAD_W1 = 3'd1,
        CMD_CALC1   = 3'd2,
        CMD_LOAD_W2 = 3'd3,
        CMD_CALC2   = 3'd4,
        CMD_STORE   = 3'd5
    } cmd_t;

    localparam int LVL_TILE = 0;
    localparam int LVL_SUB  = 1;
    localparam int LVL_F1   = 2;
    localparam int LVL_F2   = 3;
    localparam int N_LVL    = 4;
endpackage

// File: rtl/fts_idx.sv
// One loop index of the sequencer: clears, steps by one, flags its last value.
// Assumes limit is nonzero whenever last is used; clr has priority over inc.
module fts_idx #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] idx,
    output logic         last
);
    // index register
    always_ff @(posedge clk) begin
        if (!rst_n)   idx <= '0;
        else if (clr) idx <= '0;
        else if (inc) idx <= idx + 1'b1;
    end

    // final iteration of this loop level
    always_comb last = (idx == limit - 1'b1);
endmodule

// File: rtl/fts_tally.sv
// DRAM traffic counters: count accepted load and store commands by kind.
// Assumes fire marks an accepted command; clr wipes all counts at pass start.
module fts_tally
    import fts_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fire,
    input  cmd_t             kind,
    output logic [CNT_W-1:0] in_rd,
    output logic [CNT_W-1:0] w_rd,
    output logic [CNT_W-1:0] out_wr
);
    // traffic counters
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            in_rd  <= '0;
            w_rd   <= '0;
            out_wr <= '0;
        end else if (fire) begin
            if (kind == CMD_LOAD_IN) in_rd <= in_rd + 1'b1;
            if (kind == CMD_LOAD_W1 || kind == CMD_LOAD_W2) w_rd <= w_rd + 1'b1;
            if (kind == CMD_STORE) out_wr <= out_wr + 1'b1;
        end
    end
endmodule

// File: rtl/fts_seq.sv
// Fused two-layer command sequencer, input-tile-outermost order.
// Holds the current command in registers and advances on each handshake.
// Assumes counts are latched at an accepted start; zero counts are refused.
module fts_seq
    import fts_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] cfg_tiles,
    input  logic [IDX_W-1:0] cfg_subs,
    input  logic [IDX_W-1:0] cfg_f1,
    input  logic [IDX_W-1:0] cfg_f2,
    output logic             busy,
    output logic             err,
    output logic             done,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [2:0]       cmd_type,
    output logic [IDX_W-1:0] cmd_tile,
    output logic [IDX_W-1:0] cmd_sub,
    output logic [IDX_W-1:0] cmd_f1,
    output logic [IDX_W-1:0] cmd_f2,
    output logic             cmd_clear,
    output logic [CNT_W-1:0] cnt_in_rd,
    output logic [CNT_W-1:0] cnt_w_rd,
    output logic [CNT_W-1:0] cnt_out_wr
);
    cmd_t             phase, nxt_phase;
    logic             running;
    logic [IDX_W-1:0] lim [N_LVL];
    logic [IDX_W-1:0] idx [N_LVL];
    logic [N_LVL-1:0] last, clr_c, inc_c;
    logic             fire, go, refuse, fin, cfg_zero;

    // start qualification
    always_comb begin
        cfg_zero = (cfg_tiles == '0) || (cfg_subs == '0) || (cfg_f1 == '0) || (cfg_f2 == '0);
        go       = start && !running && !cfg_zero;
        refuse   = start && !running && cfg_zero;
        fire     = running && cmd_ready;
    end

    // loop index registers, one per nesting level
    for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
        fts_idx #(.W(IDX_W)) u_idx (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (go || (fire && clr_c[k])),
            .inc   (fire && inc_c[k]),
            .limit (lim[k]),
            .idx   (idx[k]),
            .last  (last[k])
        );
    end

    // next-command decision for the current phase
    always_comb begin
        nxt_phase = phase;
        clr_c     = '0;
        inc_c     = '0;
        fin       = 1'b0;
        case (phase)
            CMD_LOAD_IN: nxt_phase = CMD_LOAD_W1;
            CMD_LOAD_W1: nxt_phase = CMD_CALC1;
            CMD_CALC1: begin
                nxt_phase      = CMD_LOAD_W2;
                clr_c[LVL_F2]  = 1'b1;
            end
            CMD_LOAD_W2: nxt_phase = CMD_CALC2;
            CMD_CALC2: begin
                if (last[LVL_F2]) begin
                    clr_c[LVL_F2] = 1'b1;
                    if (last[LVL_F1]) nxt_phase = CMD_STORE;
                    else begin
                        inc_c[LVL_F1] = 1'b1;
                        nxt_phase     = CMD_LOAD_W1;
                    end
                end else begin
                    inc_c[LVL_F2] = 1'b1;
                    nxt_phase     = CMD_LOAD_W2;
                end
            end
            CMD_STORE: begin
                clr_c[LVL_F1] = 1'b1;
                if (last[LVL_SUB]) begin
                    clr_c[LVL_SUB] = 1'b1;
                    if (last[LVL_TILE]) fin = 1'b1;
                    else begin
                        inc_c[LVL_TILE] = 1'b1;
                        nxt_phase       = CMD_LOAD_IN;
                    end
                end else begin
                    inc_c[LVL_SUB] = 1'b1;
                    nxt_phase      = CMD_LOAD_W1;
                end
            end
            default: nxt_phase = CMD_LOAD_IN;
        endcase
    end

    // run state, phase, error and done flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            phase   <= CMD_LOAD_IN;
            err     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                running <= 1'b1;
                phase   <= CMD_LOAD_IN;
                err     <= 1'b0;
            end else if (refuse) begin
                err <= 1'b1;
            end else if (fire) begin
                phase <= nxt_phase;
                if (fin) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // latch loop limits at an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_LVL; k++) lim[k] <= '0;
        end else if (go) begin
            lim[LVL_TILE] <= cfg_tiles;
            lim[LVL_SUB]  <= cfg_subs;
            lim[LVL_F1]   <= cfg_f1;
            lim[LVL_F2]   <= cfg_f2;
        end
    end

    // command fields
    always_comb begin
        busy      = running;
        cmd_valid = running;
        cmd_type  = phase;
        cmd_tile  = idx[LVL_TILE];
        cmd_sub   = (phase == CMD_LOAD_IN) ? '0 : idx[LVL_SUB];
        cmd_f1    = (phase == CMD_LOAD_IN || phase == CMD_STORE) ? '0 : idx[LVL_F1];
        cmd_f2    = (phase == CMD_LOAD_W2 || phase == CMD_CALC2) ? idx[LVL_F2] : '0;
        cmd_clear = (phase == CMD_CALC2) && (idx[LVL_F1] == '0);
    end

    fts_tally #(.CNT_W(CNT_W)) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (go),
        .fire   (fire),
        .kind   (phase),
        .in_rd  (cnt_in_rd),
        .w_rd   (cnt_w_rd),
        .out_wr (cnt_out_wr)
    );
endmodule

// File: rtl/fts_seq_chk.sv
// Protocol checker for fts_seq, attached by bind.
// Assumes the same command encoding as fts_pkg.
module fts_seq_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             err,
    input logic             done,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_type,
    input logic [IDX_W-1:0] cmd_tile,
    input logic [IDX_W-1:0] cmd_sub,
    input logic [IDX_W-1:0] cmd_f1,
    input logic [IDX_W-1:0] cmd_f2,
    input logic             cmd_clear
);
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_type) && $stable(cmd_tile)
            && $stable(cmd_sub) && $stable(cmd_f1) && $stable(cmd_f2) && $stable(cmd_clear))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy); // R9
    AST_TILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_type == 3'd0) |=>
            (cmd_type == 3'd1 && cmd_sub == '0 && cmd_f1 == '0 && $stable(cmd_tile))); // R4
    AST_W2_THEN_CALC: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_type == 3'd3) |=>
            (cmd_valid && cmd_type == 3'd4 && $stable(cmd_f2) && $stable(cmd_f1))); // R2
endmodule

bind fts_seq fts_seq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .err       (err),
    .done      (done),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_type  (cmd_type),
    .cmd_tile  (cmd_tile),
    .cmd_sub   (cmd_sub),
    .cmd_f1    (cmd_f1),
    .cmd_f2    (cmd_f2),
    .cmd_clear (cmd_clear)
);

// File: tb/fts_seq_test.sv
module fts_seq_test;
    localparam int IDX_W = 4;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [IDX_W-1:0] cfg_tiles = '0, cfg_subs = '0, cfg_f1 = '0, cfg_f2 = '0;
    logic             busy, err, done, cmd_valid, cmd_clear;
    logic             cmd_ready = 1'b0;
    logic [2:0]       cmd_type;
    logic [IDX_W-1:0] cmd_tile, cmd_sub, cmd_f1, cmd_f2;
    logic [CNT_W-1:0] cnt_in_rd, cnt_w_rd, cnt_out_wr;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int seen = 0;
    int pester = 0;

    fts_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_tiles(cfg_tiles), .cfg_subs(cfg_subs), .cfg_f1(cfg_f1), .cfg_f2(cfg_f2),
        .busy(busy), .err(err), .done(done),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_type(cmd_type),
        .cmd_tile(cmd_tile), .cmd_sub(cmd_sub), .cmd_f1(cmd_f1), .cmd_f2(cmd_f2),
        .cmd_clear(cmd_clear),
        .cnt_in_rd(cnt_in_rd), .cnt_w_rd(cnt_w_rd), .cnt_out_wr(cnt_out_wr)
    );

    always #4 clk = ~clk;

    function automatic int exp_wrd(int t, int c, int f1, int f2);
        return t * c * f1 * (1 + f2);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // wait for one command, comparing it on every valid cycle until accepted
    task automatic expect_cmd(int ty, int t, int j, int f1, int f2);
        bit clr_exp;
        int got;
        int want;
        clr_exp = (ty == 4) && (f1 == 0);
        want = {ty[3:0], t[3:0], j[3:0], f1[3:0], f2[3:0], 3'b000, clr_exp};
        forever begin
            @(negedge clk);
            cmd_ready = ($urandom % 4) != 0;
            #1;
            if (cmd_valid) begin
                got = {1'b0, cmd_type, cmd_tile, cmd_sub, cmd_f1, cmd_f2, 3'b000, cmd_clear};
                if (!cmd_ready)
                    check(got == want, "R5 stalled command", got, want);
                else if (ty == 0 || ty == 5)
                    check(got == want, "R4 tile/store order", got, want);
                else if (ty == 4)
                    check(got == want, "R3 clear flag and R2 order", got, want);
                else
                    check(got == want, "R2 command order", got, want);
                if (cmd_ready) break;
            end
        end
        seen++;
        if (pester != 0 && seen == 1) begin
            start = 1'b1;
            cfg_tiles = 4'd9; cfg_subs = 4'd9; cfg_f1 = 4'd9; cfg_f2 = 4'd9;
        end
        if (pester != 0 && seen == 3) start = 1'b0;
    endtask

    task automatic run_pass(int nt, int nc, int n1, int n2, int pest);
        @(negedge clk);
        cmd_ready = 1'b0;
        cfg_tiles = nt[3:0]; cfg_subs = nc[3:0]; cfg_f1 = n1[3:0]; cfg_f2 = n2[3:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && err == 1'b0, "R9 valid start accepted", busy, 1);
        seen = 0;
        pester = pest;
        for (int t = 0; t < nt; t++) begin
            expect_cmd(0, t, 0, 0, 0);
            for (int j = 0; j < nc; j++) begin
                for (int a = 0; a < n1; a++) begin
                    expect_cmd(1, t, j, a, 0);
                    expect_cmd(2, t, j, a, 0);
                    for (int b = 0; b < n2; b++) begin
                        expect_cmd(3, t, j, a, b);
                        expect_cmd(4, t, j, a, b);
                    end
                end
                expect_cmd(5, t, j, 0, 0);
            end
        end
        pester = 0;
        start = 1'b0;
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0 && cmd_valid == 1'b0, "R6 done after last store",
              {done, busy, cmd_valid}, 3'b100);
        if (pest != 0) check(busy == 1'b0, "R8 mid-pass start ignored", busy, 0);
        check(int'(cnt_in_rd) == nt, "R7 input reads", int'(cnt_in_rd), nt);
        check(int'(cnt_w_rd) == exp_wrd(nt, nc, n1, n2), "R7 weight reads",
              int'(cnt_w_rd), exp_wrd(nt, nc, n1, n2));
        check(int'(cnt_out_wr) == nt * nc, "R7 output writes", int'(cnt_out_wr), nt * nc);
        @(negedge clk);
        check(done == 1'b0 && cmd_valid == 1'b0, "R6 done is one cycle", done, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, cmd_valid, done, err} == 4'b0000, "R1 reset flags",
              {busy, cmd_valid, done, err}, 0);
        check(cnt_in_rd == 0 && cnt_w_rd == 0 && cnt_out_wr == 0, "R1 reset counters",
              int'(cnt_w_rd), 0);

        // directed: every level wraps on one command
        run_pass(1, 1, 1, 1, 0);
        // directed: one layer-2 filter, several layer-1 filters
        run_pass(2, 2, 3, 1, 0);
        // directed: start pulsed while busy
        run_pass(2, 1, 2, 2, 1);
        // directed: larger sizes
        run_pass(3, 3, 2, 4, 0);

        // zero-count rejection
        for (int z = 0; z < 4; z++) begin
            @(negedge clk);
            cfg_tiles = (z == 0) ? 4'd0 : 4'd2;
            cfg_subs  = (z == 1) ? 4'd0 : 4'd2;
            cfg_f1    = (z == 2) ? 4'd0 : 4'd2;
            cfg_f2    = (z == 3) ? 4'd0 : 4'd2;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(err == 1'b1 && busy == 1'b0 && cmd_valid == 1'b0, "R9 zero count refused",
                  {err, busy, cmd_valid}, 3'b100);
            repeat (3) @(negedge clk);
            check(err == 1'b1 && cmd_valid == 1'b0, "R9 error held, no commands",
                  {err, cmd_valid}, 2'b10);
        end

        // random sizes with random back-pressure; run_pass checks err cleared
        for (int r = 0; r < 6; r++) begin
            run_pass(1 + ($urandom % 3), 1 + ($urandom % 3),
                     1 + ($urandom % 3), 1 + ($urandom % 4), 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule